// File: doc/BRIEF.md
# 8b/10b Transmit Encoder with Idle Rewrite

This block turns one or two bytes per clock into 8b/10b code groups. Each byte has a flag that marks it as a control character or as ordinary data. The block tracks running disparity from one code group to the next, and each byte can have its starting disparity forced to a chosen polarity. When several lanes are configured, lane 0 is encoded first. The disparity at the end of each lane is handed to the next lane in the same clock, and the disparity at the end of the last lane carries over to the next clock. While the reset input is high, every output slot sends the comma control character K28.5.

The block also rewrites idle ordered sets. When a valid K28.5 is followed by a data byte, the data byte is replaced by D16.2 or D5.6 unless it is D21.5 or D2.2. The replacement is chosen so that running disparity is negative once the pair has been sent. The K28.5 and the data byte may sit in the same clock or in two consecutive clocks.

A small state machine records what the last code group of a clock was. ST_HOLD_COMMA is entered while reset is high. It moves to ST_AFTER_COMMA when the last slot of that clock carried a valid K28.5, and to ST_DATA otherwise. ST_DATA and ST_AFTER_COMMA move between each other by the same rule. Only ST_AFTER_COMMA allows lane 0 to be rewritten on the next clock.

Top module: `tx_8b10b_encoder`

## Requirements
- R1: A byte is split into x = bits [4:0] and y = bits [7:5]. With its flag low it is encoded as Dx.y, and with its flag high as Kx.y. At negative disparity, 0x83 data gives abcdei fghj = 110001 1101, 0x78 data at positive disparity gives 001100 1100, and 0xBC control gives 001111 1010.
- R2: Lane i takes its byte from `tx_byte[8i+7:8i]`, its flag from `tx_is_ctrl[i]`, its force and value from `rd_force[i]` and `rd_force_val[i]`, and drives `code_out[10i+9:10i]`. Inside a code group, bit 0 is a (sent first), bits 1 to 5 are b c d e i, and bits 6 to 9 are f g h j.
- R3: While `rst` is high, lane 0 shows K28.5 in its negative form (001111 1010) and lane 1 shows it in its positive form (110000 0101), whatever the inputs. `ctrl_err` stays 0. Running disparity is negative at the first clock after release.
- R4: Every 6-bit sub-block has 2, 3 or 4 ones, and every 4-bit sub-block has 1, 2 or 3 ones. The sub-block may carry an excess of ones only when disparity before it is negative, and an excess of zeros only when it is positive. Disparity flips after every unbalanced sub-block.
- R5: The 256 data bytes produce distinct code groups: no code group stands for two different bytes at either starting disparity.
- R6: In one clock, the disparity at the end of lane 0 is the starting disparity of lane 1. The disparity at the end of the last lane is the starting disparity of lane 0 in the next clock.
- R7: With `rd_force[i]` set to 1, lane i starts from `rd_force_val[i]`, where 0 means negative and 1 means positive, instead of the carried disparity.
- R8: When a valid K28.5 is followed by a data byte, in the same clock or across a clock edge, the data byte is replaced. It becomes D16.2 (0x50) if disparity before it is positive, and D5.6 (0xC5) if it is negative. Disparity is negative after the replacement.
- R9: D21.5 (0xB5) and D2.2 (0x42) that follow a K28.5 are sent unchanged.
- R10: A byte whose flag is high but which is not a valid control character raises `ctrl_err[i]` for exactly that clock. The byte is encoded exactly as it would be with its flag low.
- R11: The twelve valid control characters are accepted without error, and their codes differ from the data code of the same byte value. They are K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7, that is bytes 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC, 0xF7, 0xFB, 0xFD and 0xFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset; forces comma output |
| tx_byte | input | 8*LANES | Bytes to encode, lane 0 in the low byte |
| tx_is_ctrl | input | LANES | Per-lane control-character flag |
| rd_force | input | LANES | Per-lane request to override the starting disparity |
| rd_force_val | input | LANES | Forced starting disparity, 0 negative and 1 positive |
| code_out | output | 10*LANES | Registered code groups, lane 0 in the low ten bits |
| ctrl_err | output | LANES | Registered flag for an invalid control character |

## Verification
Two functions can fall in the same clock: the idle rewrite and the hand-off of disparity from lane 0 to lane 1. The test puts K28.5 in lane 0 with lane 0's starting disparity forced to each polarity, and ordinary data in lane 1. Lane 1 must then come out as exactly D16.2 or D5.6, chosen by the disparity that K28.5 leaves behind, and the disparity computed from lane 1's ones count must end negative. The same pair is also split across a clock edge, with K28.5 in lane 1 and the data byte in lane 0 of the next clock, so that the state machine's memory of the comma is exercised.

// File: rtl/enc8b10b_pkg.sv
package enc8b10b_pkg;

    typedef enum logic [1:0] {
        ST_HOLD_COMMA  = 2'd0,
        ST_DATA        = 2'd1,
        ST_AFTER_COMMA = 2'd2
    } enc_state_e;

    localparam logic [7:0] BYTE_K28_5 = 8'hBC;
    localparam logic [7:0] BYTE_D21_5 = 8'hB5;
    localparam logic [7:0] BYTE_D2_2  = 8'h42;
    localparam logic [7:0] BYTE_D16_2 = 8'h50;
    localparam logic [7:0] BYTE_D5_6  = 8'hC5;

    // Comma in both forms, already in line order (bit 0 = a).
    localparam logic [9:0] COMMA_NEG = 10'b0101111100;
    localparam logic [9:0] COMMA_POS = 10'b1010000011;

    function automatic logic ctrl_is_valid(input logic [7:0] b);
        logic [4:0] x;
        logic [2:0] y;
        x = b[4:0];
        y = b[7:5];
        return (x == 5'd28) ||
               ((y == 3'd7) && ((x == 5'd23) || (x == 5'd27) ||
                                (x == 5'd29) || (x == 5'd30)));
    endfunction

    // 5b/6b value for negative disparity, written order: MSB is a.
    function automatic logic [5:0] six_neg(input logic [4:0] x);
        logic [5:0] w;
        unique case (x)
            5'd0:  w = 6'b100111;
            5'd1:  w = 6'b011101;
            5'd2:  w = 6'b101101;
            5'd3:  w = 6'b110001;
            5'd4:  w = 6'b110101;
            5'd5:  w = 6'b101001;
            5'd6:  w = 6'b011001;
            5'd7:  w = 6'b111000;
            5'd8:  w = 6'b111001;
            5'd9:  w = 6'b100101;
            5'd10: w = 6'b010101;
            5'd11: w = 6'b110100;
            5'd12: w = 6'b001101;
            5'd13: w = 6'b101100;
            5'd14: w = 6'b011100;
            5'd15: w = 6'b010111;
            5'd16: w = 6'b011011;
            5'd17: w = 6'b100011;
            5'd18: w = 6'b010011;
            5'd19: w = 6'b110010;
            5'd20: w = 6'b001011;
            5'd21: w = 6'b101010;
            5'd22: w = 6'b011010;
            5'd23: w = 6'b111010;
            5'd24: w = 6'b110011;
            5'd25: w = 6'b100110;
            5'd26: w = 6'b010110;
            5'd27: w = 6'b110110;
            5'd28: w = 6'b001110;
            5'd29: w = 6'b101110;
            5'd30: w = 6'b011110;
            default: w = 6'b101011;
        endcase
        return w;
    endfunction

    // 3b/4b value for negative disparity, written order: MSB is f.
    function automatic logic [3:0] four_neg(input logic [2:0] y);
        logic [3:0] w;
        unique case (y)
            3'd0: w = 4'b1011;
            3'd1: w = 4'b1001;
            3'd2: w = 4'b0101;
            3'd3: w = 4'b1100;
            3'd4: w = 4'b1101;
            3'd5: w = 4'b1010;
            3'd6: w = 4'b0110;
            default: w = 4'b1110;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/enc_6b.sv
module enc_6b
    import enc8b10b_pkg::*;
(
    input  logic [4:0] x_in,
    input  logic       is_k28,
    input  logic       rd_in,
    output logic [5:0] six_out,
    output logic       rd_mid
);
    logic [5:0] base_w;
    logic [5:0] sel_w;
    logic       unbal;

    always_comb begin
        base_w = is_k28 ? 6'b001111 : six_neg(x_in);
        unbal  = ($countones(base_w) != 3);
        // Positive disparity takes the complement for unbalanced entries and D7.
        sel_w  = (rd_in && (unbal || (x_in == 5'd7))) ? ~base_w : base_w;
        rd_mid = unbal ? ~rd_in : rd_in;
        for (int k = 0; k < 6; k++) begin
            six_out[k] = sel_w[5 - k];
        end
    end
endmodule

// File: rtl/enc_4b.sv
module enc_4b
    import enc8b10b_pkg::*;
(
    input  logic [2:0] y_in,
    input  logic       is_k28,
    input  logic       use_alt,
    input  logic       rd_mid,
    output logic [3:0] four_out,
    output logic       rd_out
);
    logic [3:0] base_w;
    logic [3:0] sel_w;
    logic       unbal;
    logic       k_flip;

    always_comb begin
        base_w = use_alt ? 4'b0111 : four_neg(y_in);
        unbal  = ($countones(base_w) != 2);
        // Balanced K28 tails invert when the 6b part left disparity negative.
        k_flip = is_k28 && !rd_mid &&
                 ((y_in == 3'd1) || (y_in == 3'd2) || (y_in == 3'd5) || (y_in == 3'd6));
        if (rd_mid && (unbal || (y_in == 3'd3))) begin
            sel_w = ~base_w;
        end else if (k_flip) begin
            sel_w = ~base_w;
        end else begin
            sel_w = base_w;
        end
        rd_out = unbal ? ~rd_mid : rd_mid;
        for (int k = 0; k < 4; k++) begin
            four_out[k] = sel_w[3 - k];
        end
    end
endmodule

// File: rtl/enc_slot.sv
module enc_slot
    import enc8b10b_pkg::*;
(
    input  logic [7:0] byte_in,
    input  logic       ctrl_in,
    input  logic       rd_in,
    output logic [9:0] code,
    output logic       rd_out
);
    logic [4:0] x;
    logic [2:0] y;
    logic       is_k28;
    logic       rd_mid;
    logic       use_alt;
    logic [5:0] six_w;
    logic [3:0] four_w;

    assign x      = byte_in[4:0];
    assign y      = byte_in[7:5];
    assign is_k28 = ctrl_in && (x == 5'd28);

    enc_6b u_six (
        .x_in    (x),
        .is_k28  (is_k28),
        .rd_in   (rd_in),
        .six_out (six_w),
        .rd_mid  (rd_mid)
    );

    // Alternate x.7 avoids a run of five equal bits across the sub-block seam.
    always_comb begin
        use_alt = (y == 3'd7) &&
                  (ctrl_in ||
                   (!rd_mid && ((x == 5'd17) || (x == 5'd18) || (x == 5'd20))) ||
                   ( rd_mid && ((x == 5'd11) || (x == 5'd13) || (x == 5'd14))));
    end

    enc_4b u_four (
        .y_in     (y),
        .is_k28   (is_k28),
        .use_alt  (use_alt),
        .rd_mid   (rd_mid),
        .four_out (four_w),
        .rd_out   (rd_out)
    );

    assign code = {four_w, six_w};
endmodule

// File: rtl/tx_8b10b_encoder.sv
module tx_8b10b_encoder
    import enc8b10b_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [8*LANES-1:0]   tx_byte,
    input  logic [LANES-1:0]     tx_is_ctrl,
    input  logic [LANES-1:0]     rd_force,
    input  logic [LANES-1:0]     rd_force_val,
    output logic [10*LANES-1:0]  code_out,
    output logic [LANES-1:0]     ctrl_err
);
    localparam int BW = 8 * LANES;
    localparam int CW = 10 * LANES;

    enc_state_e         state_q, state_d;
    logic               rd_q;
    logic [CW-1:0]      code_q;
    logic [LANES-1:0]   err_q;

    logic [LANES:0]     rd_chain;
    logic [LANES:0]     comma_chain;
    logic [LANES-1:0]   idle_hit;
    logic [LANES-1:0]   kerr;
    logic [CW-1:0]      code_d;

    // Output process: what the state tells lane 0 about the previous group.
    always_comb begin
        unique case (state_q)
            ST_AFTER_COMMA: comma_chain[0] = 1'b1;
            ST_DATA:        comma_chain[0] = 1'b0;
            default:        comma_chain[0] = 1'b0;
        endcase
    end

    assign rd_chain[0] = rd_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [7:0] raw_b;
        logic [7:0] use_b;
        logic       k_ok;
        logic       rd_start;

        assign raw_b    = tx_byte[8*i +: 8];
        assign k_ok     = tx_is_ctrl[i] && ctrl_is_valid(raw_b);
        assign kerr[i]  = tx_is_ctrl[i] && !ctrl_is_valid(raw_b);
        assign rd_start = rd_force[i] ? rd_force_val[i] : rd_chain[i];

        assign idle_hit[i] = comma_chain[i] && !tx_is_ctrl[i] &&
                             (raw_b != BYTE_D21_5) && (raw_b != BYTE_D2_2);
        assign use_b = idle_hit[i] ? (rd_start ? BYTE_D16_2 : BYTE_D5_6) : raw_b;

        enc_slot u_slot (
            .byte_in (use_b),
            .ctrl_in (k_ok),
            .rd_in   (rd_start),
            .code    (code_d[10*i +: 10]),
            .rd_out  (rd_chain[i+1])
        );

        assign comma_chain[i+1] = k_ok && (raw_b == BYTE_K28_5);

        AST_IDLE_ENDS_NEG: assert property (@(posedge clk) disable iff (rst)
            idle_hit[i] |-> !rd_chain[i+1]); // R8

        AST_GROUP_WEIGHT: assert property (@(posedge clk) disable iff (rst)
            ($countones(code_q[10*i +: 6]) >= 2) && ($countones(code_q[10*i +: 6]) <= 4) &&
            ($countones(code_q[10*i+6 +: 4]) >= 1) && ($countones(code_q[10*i+6 +: 4]) <= 3)); // R4

        AST_KERR_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
            err_q[i] |-> $past(tx_is_ctrl[i])); // R10
    end

    // Next-state logic.
    always_comb begin
        unique case (state_q)
            ST_HOLD_COMMA,
            ST_DATA,
            ST_AFTER_COMMA: state_d = comma_chain[LANES] ? ST_AFTER_COMMA : ST_DATA;
            default:        state_d = ST_DATA;
        endcase
    end

    // State register and registered outputs.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= ST_HOLD_COMMA;
            rd_q    <= 1'b0;
            err_q   <= '0;
            for (int i = 0; i < LANES; i++) begin
                code_q[10*i +: 10] <= (i % 2 == 1) ? COMMA_POS : COMMA_NEG;
            end
        end else begin
            state_q <= state_d;
            rd_q    <= rd_chain[LANES];
            err_q   <= kerr;
            code_q  <= code_d;
        end
    end

    assign code_out = code_q;
    assign ctrl_err = err_q;

    AST_RESET_COMMA: assert property (@(posedge clk)
        (rst && $past(rst)) |-> (code_q[9:0] == COMMA_NEG) && (err_q == '0)); // R3

    logic unused_bw;
    assign unused_bw = (BW == 0);
endmodule

// File: tb/tx_8b10b_encoder_tb_top.sv
`timescale 1ns/1ps
module tx_8b10b_encoder_tb_top;
    localparam int LANES = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tx_byte = '0;
    logic [1:0]  tx_is_ctrl = '0;
    logic [1:0]  rd_force = '0;
    logic [1:0]  rd_force_val = '0;
    logic [19:0] code_out;
    logic [1:0]  ctrl_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tx_8b10b_encoder #(.LANES(LANES)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .tx_byte      (tx_byte),
        .tx_is_ctrl   (tx_is_ctrl),
        .rd_force     (rd_force),
        .rd_force_val (rd_force_val),
        .code_out     (code_out),
        .ctrl_err     (ctrl_err)
    );

    function automatic logic [9:0] rev10(input logic [9:0] w);
        logic [9:0] r;
        for (int k = 0; k < 10; k++) r[k] = w[9-k];
        return r;
    endfunction

    // Disparity rule from ones counts alone (R4).
    function automatic bit grp_ok(input logic [9:0] c, input bit rin, output bit rout);
        int s6, s4;
        bit ok6, ok4, rmid;
        s6 = $countones(c[5:0]);
        s4 = $countones(c[9:6]);
        ok6  = rin ? (s6 == 3 || s6 == 2) : (s6 == 3 || s6 == 4);
        rmid = (s6 == 3) ? rin : ~rin;
        ok4  = rmid ? (s4 == 2 || s4 == 1) : (s4 == 2 || s4 == 3);
        rout = (s4 == 2) ? rmid : ~rmid;
        return ok6 && ok4;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [7:0] b0, input bit k0, input bit f0, input bit v0,
                         input logic [7:0] b1, input bit k1, input bit f1, input bit v1);
        tx_byte      = {b1, b0};
        tx_is_ctrl   = {k1, k0};
        rd_force     = {f1, f0};
        rd_force_val = {v1, v0};
    endtask

    task automatic report();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic bit valid_k(input logic [7:0] b);
        case (b)
            8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC,
            8'hF7, 8'hFB, 8'hFD, 8'hFE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    logic [9:0] data_tab [2][256];
    int         owner [1024];

    initial begin
        bit r0, r1, rd_run, rtmp;
        logic [9:0] c0, c1;
        for (int k = 0; k < 1024; k++) owner[k] = -1;

        // R3: reset holds commas regardless of inputs
        drive(8'h12, 1, 1, 1, 8'h34, 1, 1, 0);
        cyc(); cyc();
        chk(code_out[9:0] == rev10(10'b0011111010), "R3 lane0 comma", code_out[9:0], rev10(10'b0011111010));
        chk(code_out[19:10] == rev10(10'b1100000101), "R3 lane1 comma", code_out[19:10], rev10(10'b1100000101));
        chk(ctrl_err == 2'b00, "R3 no error in reset", ctrl_err, 0);
        rst = 1'b0;

        // R1/R6/R3: first clock after release starts negative; lane 1 inherits lane 0
        drive(8'h83, 0, 0, 0, 8'h78, 0, 0, 0);
        cyc();
        chk(code_out[9:0] == rev10(10'b1100011101), "R1 D3.4 neg", code_out[9:0], rev10(10'b1100011101));
        chk(code_out[19:10] == rev10(10'b0011001100), "R6 D24.3 after D3.4", code_out[19:10], rev10(10'b0011001100));

        // R7: forced positive start on lane 0
        drive(8'h83, 0, 1, 1, 8'h00, 0, 0, 0);
        cyc();
        chk(code_out[9:0] == rev10(10'b1100010010), "R7 D3.4 forced pos", code_out[9:0], rev10(10'b1100010010));
        drive(8'h78, 0, 1, 0, 8'h00, 0, 0, 0);
        cyc();
        chk(code_out[9:0] == rev10(10'b1100110011), "R7 D24.3 forced neg", code_out[9:0], rev10(10'b1100110011));

        // R4/R5/R6/R7 sweep over every data byte at both forced disparities
        rd_run = 0;
        for (int rd = 0; rd < 2; rd++) begin
            for (int b = 0; b < 256; b++) begin
                drive(b[7:0], 0, 1, rd[0], b[7:0] ^ 8'h5A, 0, 0, 0);
                cyc();
                c0 = code_out[9:0];
                c1 = code_out[19:10];
                chk(grp_ok(c0, rd[0], r0), "R4 R7 lane0 disparity", c0, rd);
                chk(grp_ok(c1, r0, r1), "R6 lane1 disparity", c1, r0);
                chk(ctrl_err == 2'b00, "R10 no error on data", ctrl_err, 0);
                data_tab[rd][b] = c0;
                chk(owner[c0] == -1 || owner[c0] == b, "R5 unique data code", owner[c0], b);
                owner[c0] = b;
                rd_run = r1;
            end
        end

        // R6: carried disparity across clocks with no forcing
        for (int i = 0; i < 48; i++) begin
            drive(8'(i * 37), 0, 0, 0, 8'(i * 91 + 5), 0, 0, 0);
            cyc();
            chk(grp_ok(code_out[9:0], rd_run, rtmp), "R6 lane0 carries", code_out[9:0], rd_run);
            chk(grp_ok(code_out[19:10], rtmp, rd_run), "R6 lane1 carries", code_out[19:10], rtmp);
        end

        // R10/R11: flag high on every byte value
        for (int b = 0; b < 256; b++) begin
            drive(b[7:0], 1, 1, 0, 8'h00, 0, 0, 0);
            cyc();
            if (valid_k(b[7:0])) begin
                chk(ctrl_err[0] == 1'b0, "R11 valid control no error", ctrl_err, 0);
                chk(grp_ok(code_out[9:0], 1'b0, rtmp), "R11 control disparity", code_out[9:0], 0);
                chk(code_out[9:0] != data_tab[0][b], "R11 control differs from data", code_out[9:0], data_tab[0][b]);
            end else begin
                chk(ctrl_err[0] == 1'b1, "R10 invalid control flagged", ctrl_err, 1);
                chk(code_out[9:0] == data_tab[0][b], "R10 invalid encoded as data", code_out[9:0], data_tab[0][b]);
            end
        end
        drive(8'h7E, 1, 0, 0, 8'h00, 0, 0, 0);
        cyc();
        chk(ctrl_err == 2'b01, "R10 error raised", ctrl_err, 1);
        drive(8'h7E, 0, 0, 0, 8'h00, 0, 0, 0);
        cyc();
        chk(ctrl_err == 2'b00, "R10 error lasts one clock", ctrl_err, 0);

        // R1: K28.5 negative form
        drive(8'hBC, 1, 1, 0, 8'h00, 0, 0, 0);
        cyc();
        chk(code_out[9:0] == rev10(10'b0011111010), "R1 K28.5 neg", code_out[9:0], rev10(10'b0011111010));
        // R8: same-clock rewrite, K28.5 from negative leaves positive -> D16.2
        chk(code_out[19:10] == rev10(10'b1001000101), "R8 D16.2 same clock", code_out[19:10], rev10(10'b1001000101));
        chk(grp_ok(code_out[19:10], 1'b1, rtmp) && !rtmp, "R8 ends negative", rtmp, 0);

        // R8: K28.5 from positive leaves negative -> D5.6
        drive(8'hBC, 1, 1, 1, 8'h33, 0, 0, 0);
        cyc();
        chk(code_out[9:0] == rev10(10'b1100000101), "R1 K28.5 pos", code_out[9:0], rev10(10'b1100000101));
        chk(code_out[19:10] == rev10(10'b1010010110), "R8 D5.6 same clock", code_out[19:10], rev10(10'b1010010110));

        // R8: across clock edge, comma in lane 1 then data in lane 0
        drive(8'h00, 0, 1, 0, 8'hBC, 1, 0, 0);
        cyc();
        drive(8'h11, 0, 0, 0, 8'h00, 0, 0, 0);
        cyc();
        chk(code_out[9:0] == rev10(10'b1001000101), "R8 D16.2 next clock", code_out[9:0], rev10(10'b1001000101));
        drive(8'h00, 0, 1, 1, 8'hBC, 1, 0, 0);
        cyc();
        drive(8'h11, 0, 0, 0, 8'h00, 0, 0, 0);
        cyc();
        chk(code_out[9:0] == rev10(10'b1010010110), "R8 D5.6 next clock", code_out[9:0], rev10(10'b1010010110));

        // R9: exempt bytes pass through after a comma
        drive(8'hBC, 1, 1, 0, 8'hB5, 0, 0, 0);
        cyc();
        chk(code_out[19:10] == rev10(10'b1010101010), "R9 D21.5 kept", code_out[19:10], rev10(10'b1010101010));
        drive(8'hBC, 1, 1, 0, 8'h42, 0, 0, 0);
        cyc();
        chk(code_out[19:10] == rev10(10'b0100100101), "R9 D2.2 kept", code_out[19:10], rev10(10'b0100100101));

        // R2: lane 1 uses its own flag and force bits
        drive(8'h00, 0, 0, 0, 8'h83, 0, 1, 1);
        cyc();
        chk(code_out[19:10] == rev10(10'b1100010010), "R2 lane1 own force", code_out[19:10], rev10(10'b1100010010));

        // R3: reset asserted mid-run
        drive(8'h55, 0, 0, 0, 8'h66, 0, 0, 0);
        rst = 1'b1;
        #1;
        chk(code_out == {rev10(10'b1100000101), rev10(10'b0011111010)}, "R3 reset mid-run", code_out, 0);
        cyc();
        rst = 1'b0;
        drive(8'h83, 0, 0, 0, 8'h00, 0, 0, 0);
        cyc();
        chk(code_out[9:0] == rev10(10'b1100011101), "R3 negative after release", code_out[9:0], rev10(10'b1100011101));

        done = 1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            report();
        end
    end
endmodule